// File: doc/BRIEF.md
# Dual Translation Lookaside Buffer with Prioritised Protection Faults

The block keeps two translation caches side by side: one serves instruction fetches, the other serves loads and stores. Each cache is organised as 4 ways of 16 sets. Each entry is a pair of 32-bit words. The tag word carries the virtual page number and an owning process number. The attribute word carries the physical frame number and five flag bits. A lookup takes a virtual page number, an access kind, a privilege flag, the current process number and four check enables. It picks the cache from the access kind and reads the set chosen by the low page bits. It compares all four ways and then runs a fixed-priority chain of protection checks. The result is a frame number, a permission mask, a fault flag and an exception vector number.

When a lookup misses or faults, the block fills in a cause register and a set-select register on its own, so that a refill handler knows what went wrong and where to put the new entry. When any way matches, whether or not the access then faults, the matched pair of words is latched into readback registers. A further readback gives the page-aligned virtual address held in the data-cache entry that the select register points at. Software writes entries through a plain register-style write port.

The lookup flows through a valid/ready request channel and a valid/ready response channel with a single result register. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. A response stays frozen while `rsp_valid` is high and `rsp_ready` is low.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, the readback, cause and select registers are 0, and every entry in both caches is zero.
- R2: A request taken on a clock edge produces its result on `rsp_*` right after that edge, with `rsp_valid` high. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid && !rsp_ready`, every `rsp_*` output holds its value. After a result is drained and no new request is taken, `rsp_valid` falls.
- R3: Kind 2'b10 (execute) uses the instruction cache with vector base 4. Kinds 2'b00 (read) and 2'b01 (write) use the data cache with vector base 8. The set is `req_vpn[3:0]`. A way matches when its tag bits [31:13] equal `req_vpn`. When several ways match, the lowest-numbered way wins.
- R4: When no way matches, the result is a fault with vector base+0, frame 0 and permission mask 0.
- R5: The first check, which has the highest priority, applies when the entry's global bit (attribute bit 4) is clear and its tag bits [7:0] differ from `cur_pid`. The result is then a fault at base+0.
- R6: The second check applies when `chk_en[2]`, the entry's kernel bit (attribute bit 2) and `req_user` are all set. The result is then a fault at base+2.
- R7: The third check applies to a write when `chk_en[3]` is set and the entry's write bit (attribute bit 1) is clear. The result is then a fault at base+3.
- R8: The fourth check applies to an execute when `chk_en[1]` is set and the entry's execute bit (attribute bit 0) is clear. The result is then a fault at base+3.
- R9: The fifth check applies when `chk_en[0]` is set and the entry's valid bit (attribute bit 3) is clear. The result is then a fault at base+1.
- R10: When a way matches and no check fires, `rsp_fault` is 0 and `rsp_vec` is 0. `rsp_pfn` is the attribute bits [31:13]. `rsp_perm` has bit 0 (read) set, bit 1 (write) equal to attribute bit 1, and bit 2 (execute) equal to attribute bit 0. On a fault after a match, `rsp_pfn` still carries the matched frame and `rsp_perm` is 0.
- R11: On every taken request with a matching way, hit or fault, `tlb_hi_rb` and `tlb_lo_rb` take the matched tag and attribute words. On a pure miss they keep their values.
- R12: On a miss or fault, `cause_rb` becomes {vpn[31:13], 3'b000, kind[9:8], cur_pid[7:0]} and `sel_rb` becomes {way 2'b00 in [5:4], set in [3:0]}. On a hit both registers keep their values.
- R13: `sel_vaddr` equals bits [31:13] of the tag word in the data-cache entry addressed by `sel_rb`, with bits [12:0] zero.
- R14: A write with `wr_en` high stores {`wr_hi`, `wr_lo`} into the entry chosen by `wr_insn` (1 selects the instruction cache), `wr_way` and `wr_idx`. A lookup taken on the same edge sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vpn | input | 19 | Virtual page number (address bits 31:13) |
| req_kind | input | 2 | 00 read, 01 write, 10 execute |
| req_user | input | 1 | Access made in user mode |
| cur_pid | input | 8 | Current process number |
| chk_en | input | 4 | Check enables: [0] valid, [1] execute, [2] kernel, [3] write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Miss or protection fault |
| rsp_vec | output | 4 | Exception vector number on a fault, else 0 |
| rsp_pfn | output | 19 | Physical frame number |
| rsp_perm | output | 3 | Granted rights: [0] read, [1] write, [2] execute |
| wr_en | input | 1 | Entry write strobe |
| wr_insn | input | 1 | 1 writes the instruction cache, 0 the data cache |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Set to write |
| wr_hi | input | 32 | Tag word to write |
| wr_lo | input | 32 | Attribute word to write |
| tlb_hi_rb | output | 32 | Last matched tag word |
| tlb_lo_rb | output | 32 | Last matched attribute word |
| cause_rb | output | 32 | Cause of the last miss or fault |
| sel_rb | output | 6 | Select register: way [5:4], set [3:0] |
| sel_vaddr | output | 32 | Page-aligned virtual address in the selected data-cache entry |

## Verification
The assertions assume that `req_kind` never carries 2'b11. They also assume `rsp_ready` is a plain consumer signal, so a result may sit for any number of cycles. The stimulus draws access kinds only from read, write and execute. It holds each request steady on the pins until it is taken, and it drops `rsp_ready` only in a dedicated back-pressure sequence. Random entries use a small pool of page numbers and process numbers, so the stimulus regularly produces multi-way matches, process mismatches and every step of the fault chain.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 13;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PID_W    = 8;
  localparam int CHK_W    = 4;
  localparam int VEC_W    = 4;
  localparam int KIND_W   = 2;
  localparam int NTLB     = 2;
  localparam int ITLB     = 0;
  localparam int DTLB     = 1;

  // attribute word flag positions
  localparam int AT_X = 0;
  localparam int AT_W = 1;
  localparam int AT_K = 2;
  localparam int AT_V = 3;
  localparam int AT_G = 4;

  // check-enable positions
  localparam int CK_V = 0;
  localparam int CK_X = 1;
  localparam int CK_K = 2;
  localparam int CK_W = 3;

  localparam logic [VEC_W-1:0] VEC_I = 4'd4;
  localparam logic [VEC_W-1:0] VEC_D = 4'd8;

  typedef enum logic [KIND_W-1:0] {
    ACC_RD = 2'b00,
    ACC_WR = 2'b01,
    ACC_EX = 2'b10
  } acc_e;

  typedef struct packed {
    logic [VA_W-1:0] hi;
    logic [VA_W-1:0] lo;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IdxW = $clog2(SETS),
  localparam int WayW = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_tlb,
  input  logic [WayW-1:0]       wr_way,
  input  logic [IdxW-1:0]       wr_idx,
  input  tlb_ent_t              wr_ent,
  input  logic                  rd_tlb,
  input  logic [IdxW-1:0]       rd_idx,
  output tlb_ent_t [WAYS-1:0]   rd_ents,
  input  logic [WayW-1:0]       rb_way,
  input  logic [IdxW-1:0]       rb_idx,
  output logic [VPN_W-1:0]      rb_vpn
);
  tlb_ent_t           rd_all [NTLB][WAYS];
  logic [VPN_W-1:0]   rb_all [WAYS];

  for (genvar t = 0; t < NTLB; t++) begin : g_tlb
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_ent_t mem_q [SETS];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
        end else if (wr_en && wr_tlb == 1'(t) && wr_way == WayW'(w)) begin
          mem_q[wr_idx] <= wr_ent;
        end
      end

      assign rd_all[t][w] = mem_q[rd_idx];

      if (t == DTLB) begin : g_rb
        assign rb_all[w] = mem_q[rb_idx].hi[VA_W-1:PG_SHIFT];
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_ents[w] = rd_all[rd_tlb][w];
  end

  assign rb_vpn = rb_all[rb_way];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  tlb_ent_t [WAYS-1:0]   ents,
  input  logic [VPN_W-1:0]      vpn,
  input  acc_e                  kind,
  input  logic                  user,
  input  logic [PID_W-1:0]      pid,
  input  logic [CHK_W-1:0]      chk,
  input  logic [VEC_W-1:0]      vbase,
  output logic                  hit_vpn,
  output tlb_ent_t              ment,
  output logic                  fault,
  output logic [VEC_W-1:0]      vec,
  output logic [VPN_W-1:0]      pfn,
  output logic [2:0]            perm
);
  logic       pid_bad, kern_bad, wr_bad, ex_bad, val_bad;
  logic [1:0] voff;

  // lowest-numbered matching way wins: scan downward, last write sticks
  always_comb begin
    hit_vpn = 1'b0;
    ment    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (ents[w].hi[VA_W-1:PG_SHIFT] == vpn) begin
        hit_vpn = 1'b1;
        ment    = ents[w];
      end
    end
  end

  assign pid_bad  = !ment.lo[AT_G] && (ment.hi[PID_W-1:0] != pid);
  assign kern_bad = chk[CK_K] && ment.lo[AT_K] && user;
  assign wr_bad   = (kind == ACC_WR) && chk[CK_W] && !ment.lo[AT_W];
  assign ex_bad   = (kind == ACC_EX) && chk[CK_X] && !ment.lo[AT_X];
  assign val_bad  = chk[CK_V] && !ment.lo[AT_V];

  always_comb begin
    fault = 1'b1;
    voff  = 2'd0;
    if (!hit_vpn)      voff = 2'd0;
    else if (pid_bad)  voff = 2'd0;
    else if (kern_bad) voff = 2'd2;
    else if (wr_bad)   voff = 2'd3;
    else if (ex_bad)   voff = 2'd3;
    else if (val_bad)  voff = 2'd1;
    else               fault = 1'b0;
  end

  assign vec  = fault ? (vbase + VEC_W'(voff)) : '0;
  assign pfn  = hit_vpn ? ment.lo[VA_W-1:PG_SHIFT] : '0;
  assign perm = fault ? 3'b000 : {ment.lo[AT_X], ment.lo[AT_W], 1'b1};
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IdxW = $clog2(SETS),
  localparam int WayW = $clog2(WAYS),
  localparam int SelW = WayW + IdxW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [KIND_W-1:0]    req_kind,
  input  logic                 req_user,
  input  logic [PID_W-1:0]     cur_pid,
  input  logic [CHK_W-1:0]     chk_en,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_fault,
  output logic [VEC_W-1:0]     rsp_vec,
  output logic [VPN_W-1:0]     rsp_pfn,
  output logic [2:0]           rsp_perm,
  input  logic                 wr_en,
  input  logic                 wr_insn,
  input  logic [WayW-1:0]      wr_way,
  input  logic [IdxW-1:0]      wr_idx,
  input  logic [VA_W-1:0]      wr_hi,
  input  logic [VA_W-1:0]      wr_lo,
  output logic [VA_W-1:0]      tlb_hi_rb,
  output logic [VA_W-1:0]      tlb_lo_rb,
  output logic [VA_W-1:0]      cause_rb,
  output logic [SelW-1:0]      sel_rb,
  output logic [VA_W-1:0]      sel_vaddr
);
  acc_e                 kind;
  logic                 is_exec, take;
  logic [IdxW-1:0]      set_idx;
  tlb_ent_t [WAYS-1:0]  ways;
  logic [VPN_W-1:0]     rb_vpn;
  logic                 hit_vpn, fault;
  tlb_ent_t             ment;
  logic [VEC_W-1:0]     vec;
  logic [VPN_W-1:0]     pfn;
  logic [2:0]           perm;

  assign kind    = acc_e'(req_kind);
  assign is_exec = (kind == ACC_EX);
  assign set_idx = req_vpn[IdxW-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign take    = req_valid && req_ready;

  tlb_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_tlb  (!wr_insn),
    .wr_way  (wr_way),
    .wr_idx  (wr_idx),
    .wr_ent  ({wr_hi, wr_lo}),
    .rd_tlb  (!is_exec),
    .rd_idx  (set_idx),
    .rd_ents (ways),
    .rb_way  (sel_rb[SelW-1:IdxW]),
    .rb_idx  (sel_rb[IdxW-1:0]),
    .rb_vpn  (rb_vpn)
  );

  tlb_match #(.WAYS(WAYS)) u_match (
    .ents    (ways),
    .vpn     (req_vpn),
    .kind    (kind),
    .user    (req_user),
    .pid     (cur_pid),
    .chk     (chk_en),
    .vbase   (is_exec ? VEC_I : VEC_D),
    .hit_vpn (hit_vpn),
    .ment    (ment),
    .fault   (fault),
    .vec     (vec),
    .pfn     (pfn),
    .perm    (perm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
      tlb_hi_rb <= '0;
      tlb_lo_rb <= '0;
      cause_rb  <= '0;
      sel_rb    <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault;
      rsp_vec   <= vec;
      rsp_pfn   <= pfn;
      rsp_perm  <= perm;
      if (hit_vpn) begin
        tlb_hi_rb <= ment.hi;
        tlb_lo_rb <= ment.lo;
      end
      if (fault) begin
        cause_rb <= {req_vpn, 3'b000, req_kind, cur_pid};
        sel_rb   <= {WayW'(0), set_idx};
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign sel_vaddr = {rb_vpn, {PG_SHIFT{1'b0}}};
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [VPN_W-1:0]     req_vpn,
  input logic [KIND_W-1:0]    req_kind,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_fault,
  input logic [VEC_W-1:0]     rsp_vec,
  input logic [VPN_W-1:0]     rsp_pfn,
  input logic [2:0]           rsp_perm,
  input logic [VA_W-1:0]      cause_rb,
  input logic [5:0]           sel_rb
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_vec)
                                && $stable(rsp_pfn) && $stable(rsp_perm));

  a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r10_hit_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_perm[0] && rsp_vec == '0);

  a_r4_fault_noperm: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_perm == 3'b000);

  a_r3_ivec: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'b10 |=> !rsp_fault || rsp_vec[3:2] == 2'b01);

  a_r3_dvec: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind != 2'b10 |=> !rsp_fault || rsp_vec[3:2] == 2'b10);

  a_r12_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##1 rsp_fault |-> cause_rb[31:13] == $past(req_vpn)
                                               && sel_rb[3:0] == $past(req_vpn[3:0]));

  a_r12_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##1 !rsp_fault |-> $stable(cause_rb) && $stable(sel_rb));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [18:0] req_vpn = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [3:0]  chk_en = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_fault;
  logic [3:0]  rsp_vec;
  logic [18:0] rsp_pfn;
  logic [2:0]  rsp_perm;
  logic        wr_en = 1'b0, wr_insn = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic [31:0] tlb_hi_rb, tlb_lo_rb, cause_rb, sel_vaddr;
  logic [5:0]  sel_rb;

  always #4 clk = ~clk;

  tlb_xlate dut_i (.*);

  int checks = 0, errors = 0;
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  logic [31:0] e_hi = '0, e_lo = '0, e_cause = '0;
  logic [5:0]  e_sel = '0;

  typedef struct packed {
    logic        match, fault;
    logic [3:0]  vec;
    logic [18:0] pfn;
    logic [2:0]  perm;
    logic [31:0] hi, lo;
  } pred_t;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic pred_t predict(logic [18:0] vpn, logic [1:0] kind, logic user,
                                    logic [7:0] pid, logic [3:0] ce);
    pred_t p;
    int t = (kind == 2'b10) ? 0 : 1;
    logic [3:0] base = (kind == 2'b10) ? 4'd4 : 4'd8;
    p = '0;
    for (int w = 3; w >= 0; w--)
      if (m_hi[t][w][vpn[3:0]][31:13] == vpn) begin
        p.match = 1'b1; p.hi = m_hi[t][w][vpn[3:0]]; p.lo = m_lo[t][w][vpn[3:0]];
      end
    p.fault = 1'b1;
    if (!p.match)                                       p.vec = base;
    else if (!p.lo[4] && p.hi[7:0] != pid)              p.vec = base;
    else if (ce[2] && p.lo[2] && user)                  p.vec = base + 4'd2;
    else if (kind == 2'b01 && ce[3] && !p.lo[1])        p.vec = base + 4'd3;
    else if (kind == 2'b10 && ce[1] && !p.lo[0])        p.vec = base + 4'd3;
    else if (ce[0] && !p.lo[3])                         p.vec = base + 4'd1;
    else begin p.fault = 1'b0; p.vec = '0; end
    p.pfn  = p.match ? p.lo[31:13] : '0;
    p.perm = p.fault ? 3'b000 : {p.lo[0], p.lo[1], 1'b1};
    return p;
  endfunction

  task automatic commit(pred_t p, logic [18:0] vpn, logic [1:0] kind, logic [7:0] pid);
    if (p.match) begin e_hi = p.hi; e_lo = p.lo; end
    if (p.fault) begin
      e_cause = {vpn, 3'b000, kind, pid};
      e_sel   = {2'b00, vpn[3:0]};
    end
  endtask

  task automatic cmp_out(pred_t p, string tag);
    chk({tag, " vec/fault"}, {27'b0, p.fault, rsp_vec}, {27'b0, p.fault, p.vec});
    chk({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, p.fault});
    chk("R10 pfn", {13'b0, rsp_pfn}, {13'b0, p.pfn});
    chk("R10 perm", {29'b0, rsp_perm}, {29'b0, p.perm});
    chk("R2 valid", {31'b0, rsp_valid}, 32'd1);
    chk("R11 hi readback", tlb_hi_rb, e_hi);
    chk("R11 lo readback", tlb_lo_rb, e_lo);
    chk("R12 cause", cause_rb, e_cause);
    chk("R12 select", {26'b0, sel_rb}, {26'b0, e_sel});
    chk("R13 sel_vaddr", sel_vaddr, {m_hi[1][e_sel[5:4]][e_sel[3:0]][31:13], 13'b0});
  endtask

  task automatic drive_req(logic [18:0] vpn, logic [1:0] kind, logic user,
                           logic [7:0] pid, logic [3:0] ce);
    req_valid = 1'b1; req_vpn = vpn; req_kind = kind;
    req_user = user; cur_pid = pid; chk_en = ce;
  endtask

  task automatic lookup(logic [18:0] vpn, logic [1:0] kind, logic user, logic [7:0] pid,
                        logic [3:0] ce, string tag, int exp_vec = -1);
    pred_t p;
    @(negedge clk);
    drive_req(vpn, kind, user, pid, ce);
    p = predict(vpn, kind, user, pid, ce);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    commit(p, vpn, kind, pid);
    cmp_out(p, tag);
    if (exp_vec >= 0) chk({tag, " fixed vec"}, {28'b0, rsp_vec}, 32'(exp_vec));
  endtask

  task automatic write_ent(logic insn, int way, int idx, logic [31:0] hi, logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_insn = insn; wr_way = 2'(way); wr_idx = 4'(idx); wr_hi = hi; wr_lo = lo;
    @(posedge clk);
    m_hi[insn ? 0 : 1][way][idx] = hi;
    m_lo[insn ? 0 : 1][way][idx] = lo;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // attribute word: {pfn, 8'b0, g, v, k, w, x}
  function automatic logic [31:0] mk_lo(logic [18:0] pfn, logic [4:0] flags);
    return {pfn, 8'b0, flags};
  endfunction

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pred_t pa, pb;
    void'($urandom(32'h00c0ffee));
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++) begin m_hi[t][w][s] = '0; m_lo[t][w][s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 cause", cause_rb, 32'd0);
    chk("R1 select", {26'b0, sel_rb}, 32'd0);
    chk("R1 hi readback", tlb_hi_rb, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel_vaddr", sel_vaddr, 32'd0);

    // data entry, vpn 0x00105, pid 7, non-global, valid, write, exec
    write_ent(1'b0, 2, 5, {19'h00105, 5'b0, 8'd7}, mk_lo(19'h1234A, 5'b01011));
    lookup(19'h00105, 2'b00, 1'b0, 8'd7, 4'hF, "R10 hit");
    lookup(19'h00105, 2'b00, 1'b0, 8'd3, 4'hF, "R5 pid", 8);
    lookup(19'h00205, 2'b00, 1'b0, 8'd7, 4'hF, "R4 miss", 8);
    lookup(19'h00205, 2'b10, 1'b0, 8'd7, 4'hF, "R4 exec miss", 4);
    // kernel page
    write_ent(1'b0, 0, 6, {19'h00306, 5'b0, 8'd1}, mk_lo(19'h0ABCD, 5'b01110));
    lookup(19'h00306, 2'b00, 1'b1, 8'd1, 4'hF, "R6 kernel", 10);
    lookup(19'h00306, 2'b00, 1'b0, 8'd1, 4'hF, "R6 kernel priv ok");
    lookup(19'h00306, 2'b01, 1'b1, 8'd2, 4'hF, "R5 pid over kernel", 8);
    // write protected, global
    write_ent(1'b0, 1, 7, {19'h00407, 5'b0, 8'd9}, mk_lo(19'h01111, 5'b11001));
    lookup(19'h00407, 2'b01, 1'b0, 8'd4, 4'hF, "R7 write", 11);
    lookup(19'h00407, 2'b01, 1'b0, 8'd4, 4'h7, "R7 check off");
    // instruction entry without execute
    write_ent(1'b1, 3, 8, {19'h00508, 5'b0, 8'd0}, mk_lo(19'h02222, 5'b11000));
    lookup(19'h00508, 2'b10, 1'b0, 8'd0, 4'hF, "R8 exec", 7);
    lookup(19'h00508, 2'b10, 1'b0, 8'd0, 4'hD, "R8 check off");
    lookup(19'h00508, 2'b00, 1'b0, 8'd0, 4'hF, "R3 side miss", 8);
    // invalid entry
    write_ent(1'b0, 3, 9, {19'h00609, 5'b0, 8'd0}, mk_lo(19'h03333, 5'b10011));
    lookup(19'h00609, 2'b00, 1'b0, 8'd0, 4'hF, "R9 valid", 9);
    lookup(19'h00609, 2'b00, 1'b0, 8'd0, 4'hE, "R9 check off");
    // two ways with the same vpn: lowest way wins
    write_ent(1'b0, 3, 10, {19'h0070A, 5'b0, 8'd0}, mk_lo(19'h04444, 5'b11011));
    write_ent(1'b0, 1, 10, {19'h0070A, 5'b0, 8'd0}, mk_lo(19'h05555, 5'b11011));
    lookup(19'h0070A, 2'b00, 1'b0, 8'd0, 4'hF, "R3 lowest way");
    chk("R3 lowest way pfn", {13'b0, rsp_pfn}, 32'h05555);

    // R14: write and lookup on the same edge
    @(negedge clk);
    pa = predict(19'h0080B, 2'b00, 1'b0, 8'd0, 4'hF);
    drive_req(19'h0080B, 2'b00, 1'b0, 8'd0, 4'hF);
    wr_en = 1'b1; wr_insn = 1'b0; wr_way = 2'd0; wr_idx = 4'd11;
    wr_hi = {19'h0080B, 13'd0}; wr_lo = mk_lo(19'h06666, 5'b11011);
    @(posedge clk);
    m_hi[1][0][11] = wr_hi; m_lo[1][0][11] = wr_lo;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    commit(pa, 19'h0080B, 2'b00, 8'd0);
    cmp_out(pa, "R14 old contents");
    lookup(19'h0080B, 2'b00, 1'b0, 8'd0, 4'hF, "R14 new contents");
    chk("R14 written pfn", {13'b0, rsp_pfn}, 32'h06666);

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive_req(19'h00105, 2'b00, 1'b0, 8'd7, 4'hF);
    pa = predict(19'h00105, 2'b00, 1'b0, 8'd7, 4'hF);
    @(posedge clk);
    @(negedge clk);
    commit(pa, 19'h00105, 2'b00, 8'd7);
    drive_req(19'h00306, 2'b00, 1'b1, 8'd1, 4'hF);
    cmp_out(pa, "R2 first");
    for (int i = 0; i < 3; i++) begin
      chk("R2 ready low", {31'b0, req_ready}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R2 held pfn", {13'b0, rsp_pfn}, {13'b0, pa.pfn});
      chk("R2 held fault", {31'b0, rsp_fault}, {31'b0, pa.fault});
    end
    rsp_ready = 1'b1;
    pb = predict(19'h00306, 2'b00, 1'b1, 8'd1, 4'hF);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    commit(pb, 19'h00306, 2'b00, 8'd1);
    cmp_out(pb, "R2 second");
    @(posedge clk);
    @(negedge clk);
    chk("R2 drained", {31'b0, rsp_valid}, 32'd0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  idx = 4'($urandom % 4);
      logic [18:0] vpn = {15'(1 + $urandom % 4), idx};
      if ($urandom % 3 == 0)
        write_ent(1'($urandom % 2), int'($urandom % 4), int'(idx),
                  {vpn, 5'b0, 8'($urandom % 3)}, mk_lo(19'($urandom), 5'($urandom)));
      else
        lookup(vpn, 2'($urandom % 3), 1'($urandom % 2), 8'($urandom % 3),
               4'($urandom), "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule